// File: doc/BRIEF.md
# Page-Mode DRAM Burst Read Sequencer

This block turns a single host read request into a four-beat burst from one open page of an asynchronous page-mode DRAM. It opens the row with the row strobe and then steps the column address once per beat. Each beat's word is returned to the host with a one-clock valid pulse. The row strobe is held low for the whole burst and is released after the last beat.

A static mode input picks the beat timing. In classic mode the column strobe returns high between beats, and the part's output is invalid while it is high, so beats after the first cost three clocks. In extended-data-out mode the part keeps driving its last word while the next column is being set up, so beats after the first cost two clocks. The first beat costs five clocks in both modes. The mode is sampled when a request is accepted.

The host raises `req` with an address and holds it. The request is taken on a clock edge where `ready` is high. `ready` stays low for the whole burst, so a request that arrives during a burst waits until the row strobe has been high for one clock.

Top module: `dram_burst_seq`

## Requirements
- R1: During and straight after reset, `ready`=1, `ras_n`=1, `cas_n`=1 and `rd_valid`=0.
- R2: On an edge with `req`=1 and `ready`=1, the request is accepted. In the next clock (cycle 1), `ras_n`=0, `mem_addr` carries the row (`req_addr[ROW_W+COL_W-1:COL_W]`) and `ready`=0. `ready` stays 0 while `ras_n` is 0.
- R3: In cycle 2, `cas_n`=0 and `mem_addr` is the first column, `req_addr[COL_W-1:0]`. The column strobe stays low in cycles 2 to 4.
- R4: Beat k (k = 0..3) uses column (first column + k) mod 2^COL_W, so the column wraps inside the page.
- R5: In classic mode (`edo_mode`=0), `rd_valid` is a one-clock pulse in cycles 5, 8, 11 and 14, and `ready` returns to 1 in cycle 15.
- R6: In extended-data-out mode (`edo_mode`=1), `rd_valid` pulses in cycles 5, 7, 9 and 11, and `ready` returns to 1 in cycle 12.
- R7: While `rd_valid`=1, `rd_data` holds the memory word at the open row and that beat's column.
- R8: Each later beat presents its new column with `cas_n`=1 in the cycle of the previous beat's valid pulse. `cas_n` is then 0 for two cycles in classic mode, or for one cycle in extended-data-out mode.
- R9: `ras_n` is 0 from cycle 1 through the final valid cycle and is 1 in the cycle after it. `cas_n` is never 0 while `ras_n` is 1.
- R10: A request held high during a burst is ignored until `ready` returns. It is then accepted, so `ras_n` is high for exactly one clock between back-to-back bursts.
- R11: A change of `edo_mode` after acceptance has no effect on the running burst's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edo_mode | input | 1 | 1 = extended-data-out timing, 0 = classic page timing |
| req | input | 1 | Burst read request |
| req_addr | input | ROW_W+COL_W | Row (upper bits) and first column (lower bits) |
| ready | output | 1 | Idle and able to accept a request |
| rd_valid | output | 1 | One-clock pulse per returned beat |
| rd_data | output | DATA_W | Returned word, held until the next beat |
| ras_n | output | 1 | Active-low row strobe |
| cas_n | output | 1 | Active-low column strobe |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_dq | input | DATA_W | Data driven by the DRAM |

## Verification
The hardest situation to reach is a request that is already pending when a burst ends, because the acceptance must land exactly one clock after the row strobe rises. The bench holds `req` high from the first cycle of a burst and checks the idle gap and the new row in the following cycles. A mode change in the middle of a burst is the other hard case. The bench flips `edo_mode` in cycle 3 and checks that every valid pulse still follows the accepted mode. Column wrap is reached by starting bursts at the last columns of a page.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_CAS,
        ST_PRE,
        ST_LAST
    } dbs_state_e;

    // Clock budgets: clocks with the column strobe low in the first beat,
    // and in each later beat for the two modes
    localparam int FIRST_LOW_DEF = 3;
    localparam int PAGE_LOW_DEF  = 2;
    localparam int EDO_LOW_DEF   = 1;
    localparam int BEATS_DEF     = 4;

endpackage

// File: rtl/dbs_low_counter.sv
module dbs_low_counter #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

    // R8: a load sets the count seen in the next cycle
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/dbs_col_gen.sv
module dbs_col_gen #(
    parameter int COL_W = 10,
    parameter int BW    = 2
) (
    input  logic [COL_W-1:0] base,
    input  logic [BW-1:0]    beat,
    output logic [COL_W-1:0] col
);
    // R4: the column steps by one per beat and wraps inside the page
    always_comb begin
        col = base + COL_W'(beat);
    end
endmodule

// File: rtl/dram_burst_seq.sv
module dram_burst_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DATA_W    = 64,
    parameter int BEATS     = BEATS_DEF,
    parameter int FIRST_LOW = FIRST_LOW_DEF,
    parameter int PAGE_LOW  = PAGE_LOW_DEF,
    parameter int EDO_LOW   = EDO_LOW_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edo_mode,
    input  logic                   req,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    output logic                   ready,
    output logic                   rd_valid,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   ras_n,
    output logic                   cas_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    input  logic [DATA_W-1:0]      mem_dq
);
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int MAXL_A = (FIRST_LOW > PAGE_LOW) ? FIRST_LOW : PAGE_LOW;
    localparam int MAXL   = (MAXL_A > EDO_LOW) ? MAXL_A : EDO_LOW;
    localparam int CW     = $clog2(MAXL + 1);

    typedef struct packed {
        dbs_state_e       st;
        logic [BW-1:0]    beat;
        logic             mode;
        logic [COL_W-1:0] base;
        logic             ras_n;
        logic             cas_n;
        logic             ready;
        logic             valid;
        logic [MA_W-1:0]  addr;
        logic [DATA_W-1:0] data;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          lc_load;
    logic [CW-1:0] lc_val;
    logic          lc_zero;
    logic [BW-1:0] col_beat;
    logic [COL_W-1:0] col_addr;

    // Counter reload on entry to every column-low phase
    assign lc_load  = (r_q.st == ST_ROW) || (r_q.st == ST_PRE);
    assign lc_val   = (r_q.st == ST_ROW) ? CW'(FIRST_LOW - 1)
                    : (r_q.mode ? CW'(EDO_LOW - 1) : CW'(PAGE_LOW - 1));
    assign col_beat = (r_q.st == ST_ROW) ? '0 : (r_q.beat + 1'b1);

    dbs_low_counter #(.CW(CW)) low_cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lc_load),
        .load_val (lc_val),
        .zero     (lc_zero)
    );

    dbs_col_gen #(.COL_W(COL_W), .BW(BW)) col_gen_i (
        .base (r_q.base),
        .beat (col_beat),
        .col  (col_addr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.ready = 1'b1;
                r_d.ras_n = 1'b1;
                r_d.cas_n = 1'b1;
                if (req) begin
                    r_d.st    = ST_ROW;
                    r_d.ras_n = 1'b0;
                    r_d.ready = 1'b0;
                    r_d.mode  = edo_mode;
                    r_d.base  = req_addr[COL_W-1:0];
                    r_d.addr  = MA_W'(req_addr[ROW_W+COL_W-1:COL_W]);
                end
            end
            ST_ROW: begin
                r_d.st    = ST_CAS;
                r_d.beat  = '0;
                r_d.cas_n = 1'b0;
                r_d.addr  = MA_W'(col_addr);
            end
            ST_CAS: begin
                if (lc_zero) begin
                    r_d.valid = 1'b1;
                    r_d.data  = mem_dq;
                    r_d.cas_n = 1'b1;
                    if (r_q.beat == BW'(BEATS - 1)) begin
                        r_d.st = ST_LAST;
                    end else begin
                        r_d.st   = ST_PRE;
                        r_d.beat = r_q.beat + 1'b1;
                        r_d.addr = MA_W'(col_addr);
                    end
                end
            end
            ST_PRE: begin
                r_d.st    = ST_CAS;
                r_d.cas_n = 1'b0;
            end
            ST_LAST: begin
                r_d.st    = ST_IDLE;
                r_d.ras_n = 1'b1;
                r_d.ready = 1'b1;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.ready <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready    = r_q.ready;
    assign rd_valid = r_q.valid;
    assign rd_data  = r_q.data;
    assign ras_n    = r_q.ras_n;
    assign cas_n    = r_q.cas_n;
    assign mem_addr = r_q.addr;

    // R9
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !ready);

    // R10
    ras_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(ready) && $past(req)));

    // R7
    valid_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !ras_n);

endmodule

// File: tb/dram_burst_seq_tb_top.sv
`timescale 1ns/1ps
module dram_burst_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        edo_mode;
    logic        req;
    logic [19:0] req_addr;
    logic        ready;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        ras_n;
    logic        cas_n;
    logic [9:0]  mem_addr;
    logic [63:0] mem_dq;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    dram_burst_seq dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .edo_mode (edo_mode),
        .req      (req),
        .req_addr (req_addr),
        .ready    (ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .mem_addr (mem_addr),
        .mem_dq   (mem_dq)
    );

    // Asynchronous DRAM model
    function automatic logic [63:0] mdata(input logic [9:0] r, input logic [9:0] c);
        return {16'hD0A0, 6'd0, r, 22'd0, c};
    endfunction

    logic [9:0]  open_row = '0;
    logic        prev_ras = 1'b1;
    logic [63:0] last_word = '0;
    logic        edo_model = 1'b0;

    always @(posedge clk) begin
        if (!ras_n && prev_ras) open_row <= mem_addr;
        prev_ras <= ras_n;
        if (!cas_n) last_word <= mdata(open_row, mem_addr);
    end

    always_comb begin
        if (!cas_n)         mem_dq = mdata(open_row, mem_addr);
        else if (edo_model) mem_dq = last_word;
        else                mem_dq = '0;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic       edo;
        logic [9:0] row;
        logic [9:0] col;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 10'd5,    10'd0},
        '{1'b1, 10'd5,    10'd100},
        '{1'b0, 10'd77,   10'd1022},
        '{1'b1, 10'd300,  10'd1023},
        '{1'b0, 10'd1023, 10'd511},
        '{1'b1, 10'd0,    10'd3}
    };

    // One burst; cycle 1 is the clock after the accepting edge
    task automatic run_burst(input logic edo, input logic [9:0] row,
                             input logic [9:0] col, input logic keep_req,
                             input logic flip_mode, output int bad_valid);
        int l;
        int len;
        bad_valid = 0;
        l   = edo ? 2 : 3;
        len = 5 + 3 * l;
        @(negedge clk);
        chk(ready == 1'b1, "R2 ready before request", 64'(ready), 64'd1);
        edo_mode  = edo;
        edo_model = edo;
        req       = 1'b1;
        req_addr  = {row, col};
        for (int c = 1; c <= len + 1; c++) begin
            logic       exp_valid;
            logic       exp_cas_low;
            int         k;
            logic [9:0] exp_col;
            @(negedge clk);
            if (c == 1 && !keep_req) req = 1'b0;
            if (flip_mode && c == 3) edo_mode = ~edo;
            exp_valid   = (c >= 5) && ((c - 5) % l == 0) && ((c - 5) / l <= 3);
            exp_cas_low = ((c >= 2) && (c <= 4)) ||
                          ((c > 5) && ((c - 5) % l != 0) && ((c - 5) / l < 3));
            k           = (c <= 4) ? 0 : ((c - 5) / l + 1);
            exp_col     = col + 10'(k);
            chk(ras_n == (c > len), "R9 ras_n", 64'(ras_n), 64'(c > len));
            chk(ready == (c > len), "R2 ready", 64'(ready), 64'(c > len));
            chk(cas_n == !exp_cas_low, "R8 cas_n", 64'(cas_n), 64'(!exp_cas_low));
            if (rd_valid != exp_valid) bad_valid++;
            chk(rd_valid == exp_valid, edo ? "R6 rd_valid" : "R5 rd_valid",
                64'(rd_valid), 64'(exp_valid));
            if (c == 1)
                chk(mem_addr == row, "R2 row address", 64'(mem_addr), 64'(row));
            else if (exp_cas_low && c <= 4)
                chk(mem_addr == col, "R3 first column", 64'(mem_addr), 64'(col));
            else if (exp_cas_low)
                chk(mem_addr == exp_col, "R4 column step", 64'(mem_addr), 64'(exp_col));
            if (exp_valid)
                chk(rd_data == mdata(row, col + 10'((c - 5) / l)), "R7 rd_data",
                    rd_data, mdata(row, col + 10'((c - 5) / l)));
        end
        edo_mode = edo;
    endtask

    initial begin
        #1_000_000;
        nchk++;
        nerr++;
        $display("FAIL watchdog R2 act=hung exp=burst complete");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int bad;
        rst_n    = 1'b0;
        req      = 1'b0;
        edo_mode = 1'b0;
        req_addr = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, held and after release
        chk(ready == 1'b1, "R1 ready in reset", 64'(ready), 64'd1);
        chk(ras_n == 1'b1, "R1 ras_n in reset", 64'(ras_n), 64'd1);
        chk(cas_n == 1'b1, "R1 cas_n in reset", 64'(cas_n), 64'd1);
        chk(rd_valid == 1'b0, "R1 rd_valid in reset", 64'(rd_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n == 1'b1 && ready == 1'b1, "R1 idle after reset",
            64'({ras_n, ready}), 64'd3);

        foreach (VECS[i]) begin
            run_burst(VECS[i].edo, VECS[i].row, VECS[i].col, 1'b0, 1'b0, bad);
        end

        // R11: mode flipped mid-burst, timing must follow the accepted mode
        run_burst(1'b0, 10'd12, 10'd40, 1'b0, 1'b1, bad);
        chk(bad == 0, "R11 classic timing kept", 64'(bad), 64'd0);
        run_burst(1'b1, 10'd13, 10'd41, 1'b0, 1'b1, bad);
        chk(bad == 0, "R11 edo timing kept", 64'(bad), 64'd0);

        // R10: request held through a burst is taken one clock after release
        run_burst(1'b1, 10'd200, 10'd8, 1'b1, 1'b0, bad);
        req_addr = {10'd201, 10'd9};
        @(negedge clk);
        chk(ras_n == 1'b0, "R10 held request accepted", 64'(ras_n), 64'd0);
        chk(mem_addr == 10'd201, "R10 new row", 64'(mem_addr), 64'd201);
        req = 1'b0;
        repeat (20) @(negedge clk);
        chk(ready == 1'b1 && ras_n == 1'b1, "R10 idle after second burst",
            64'({ready, ras_n}), 64'd3);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule